// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, the A port and the B port, with one independent data path in each direction. Each path has its own latch enable, its own clock and its own output enable. One storage element per bit and per direction serves three modes. While the latch enable is high, the path is a transparent wire. While the latch enable is low and the clock holds still, the path keeps its stored word. While the latch enable is low, a rising clock edge loads the current input.

Tri-state pins are split into plain signals: one input word, one data output and one output-enable flag per port, plus a per-bit mask that says which input bits are actually being driven. The surrounding logic or the testbench resolves the real wire. A bus-hold model is provided for simulation and can be switched off by a parameter. When it is on, an input bit that nobody drives is replaced by the last value that was driven on it.

The A-to-B output enable is active high by default, and the B-to-A output enable is active low. Both polarities are parameters. Each direction has an asynchronous active-low reset, released in step with that direction's own clock.

Top module: `reg_bus_xcvr`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals the sampled A word with no clock edge needed. While `ba_le` is 1, `a_out` equals the sampled B word in the same way.
- R2: While a path's latch enable is 0 and its clock does not rise, the path's output stays constant whatever its input does.
- R3: While a path's latch enable is 0, a rising edge of its clock loads the sampled input word, and that word appears on the output right after the edge. A falling clock edge has no effect.
- R4: When a latch enable falls from 1 to 0 with no clock edge, the output keeps the last word that was passed through transparently.
- R5: With the default polarity, `b_oe` is 1 exactly when `ab_oe_ctl` is 1.
- R6: With the default polarity, `a_oe` is 1 exactly when `ba_oe_ctl` is 0 (active low).
- R7: Every bit of the WIDTH-bit words (default 18) behaves identically and independently, for any data pattern.
- R8: With HOLD_EN=1, an input bit whose drive-mask bit (`a_drv`/`b_drv`) is 0 is sampled as the last value it had while its mask bit was 1. The values presented on undriven bits are ignored.
- R9: While `rst_n` is 0, both stored words are cleared. After reset, with both latch enables at 0, `a_out` and `b_out` read 0.
- R10: The controls of one direction have no effect on the output word or output enable of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both paths |
| a_in | input | WIDTH | Resolved value seen on the A bus |
| a_drv | input | WIDTH | Per-bit flag: the A bus bit is actively driven |
| a_out | output | WIDTH | Data the block places on the A bus |
| a_oe | output | 1 | Block drives the A bus |
| b_in | input | WIDTH | Resolved value seen on the B bus |
| b_drv | input | WIDTH | Per-bit flag: the B bus bit is actively driven |
| b_out | output | WIDTH | Data the block places on the B bus |
| b_oe | output | 1 | Block drives the B bus |
| ab_oe_ctl | input | 1 | Output enable control of the A-to-B path |
| ab_le | input | 1 | Latch enable of the A-to-B path |
| ab_clk | input | 1 | Clock of the A-to-B path |
| ba_oe_ctl | input | 1 | Output enable control of the B-to-A path |
| ba_le | input | 1 | Latch enable of the B-to-A path |
| ba_clk | input | 1 | Clock of the B-to-A path |

## Verification
Directed sequences first open a latch and change the data, then close it and change the data again, then pulse the clock. This separates the transparent, hold and edge modes, and it shows that the value kept after closing the latch is the last transparent word and not an older clocked one. Floating bits are then driven with changing junk, which tells a real bus-hold from a path that just passes its raw input. A long random mix of single-control steps follows. In that mix, only one of data, latch enable, clock level or output enable changes at a time, and turning a direction on can feed one path's output back into the other path's input. Every step is compared with a bench model of both paths and both keepers.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Which element currently supplies a path's stored word
  typedef enum logic {
    SRC_LATCH = 1'b0,
    SRC_FLOP  = 1'b1
  } src_e;

  // Map an output-enable control level to a drive flag for a given polarity
  function automatic logic oe_on(input logic ctl, input bit act_high);
    return act_high ? ctl : ~ctl;
  endfunction

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb sync_nxt = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_nxt;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int WIDTH   = 18,
  parameter bit HOLD_EN = 1'b1
) (
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] pin_drv,
  output logic [WIDTH-1:0] pin_smp
);
  if (HOLD_EN) begin : g_hold
    logic [WIDTH-1:0] keep_q;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_latch begin
        if (pin_drv[i]) keep_q[i] = pin_in[i];
      end
      assign pin_smp[i] = pin_drv[i] ? pin_in[i] : keep_q[i];
    end
  end else begin : g_raw
    logic unused_drv;
    assign unused_drv = ^pin_drv;
    assign pin_smp    = pin_in;
  end
endmodule

// File: rtl/xcvr_store_cell.sv
module xcvr_store_cell
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] ff_q;
  logic [WIDTH-1:0] ff_nxt;
  logic             ff_en;
  src_e             src_q;

  // Level-sensitive half: follows d while le is high, closes on le falling
  always_latch begin
    if (!rst_n)  lat_q = '0;
    else if (le) lat_q = d;
  end

  // Edge half: loads only while the latch is closed
  assign ff_en = ~le;
  always_comb ff_nxt = ff_en ? d : ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= ff_nxt;
  end

  // Source select: an open latch forces the latch side, a clock edge hands over to the flop
  always_ff @(posedge clk or negedge rst_n or posedge le) begin
    if (!rst_n)  src_q <= SRC_LATCH;
    else if (le) src_q <= SRC_LATCH;
    else         src_q <= SRC_FLOP;
  end

  assign q = (src_q == SRC_FLOP) ? ff_q : lat_q;

  // R1
  transparent_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> (q == d));

  // R3
  edge_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> (ff_q == $past(d)));

  // R3
  open_latch_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> (src_q == SRC_LATCH));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ff_q == '0));
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH      = 18,
  parameter bit OE_AB_HIGH = 1'b1,
  parameter bit OE_BA_HIGH = 1'b0,
  parameter bit HOLD_EN    = 1'b1
) (
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] a_drv,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] b_drv,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             ab_oe_ctl,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ba_oe_ctl,
  input  logic             ba_le,
  input  logic             ba_clk
);
  logic [WIDTH-1:0] a_smp;
  logic [WIDTH-1:0] b_smp;
  logic [WIDTH-1:0] ab_q;
  logic [WIDTH-1:0] ba_q;
  logic             ab_rst_n;
  logic             ba_rst_n;

  xcvr_keeper #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) u_keep_a (
    .pin_in(a_in), .pin_drv(a_drv), .pin_smp(a_smp)
  );
  xcvr_keeper #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) u_keep_b (
    .pin_in(b_in), .pin_drv(b_drv), .pin_smp(b_smp)
  );

  xcvr_rst_sync u_rst_ab (.clk(ab_clk), .arst_n(rst_n), .srst_n(ab_rst_n));
  xcvr_rst_sync u_rst_ba (.clk(ba_clk), .arst_n(rst_n), .srst_n(ba_rst_n));

  xcvr_store_cell #(.WIDTH(WIDTH)) u_path_ab (
    .clk(ab_clk), .rst_n(ab_rst_n), .le(ab_le), .d(a_smp), .q(ab_q)
  );
  xcvr_store_cell #(.WIDTH(WIDTH)) u_path_ba (
    .clk(ba_clk), .rst_n(ba_rst_n), .le(ba_le), .d(b_smp), .q(ba_q)
  );

  assign b_out = ab_q;
  assign a_out = ba_q;
  assign b_oe  = oe_on(ab_oe_ctl, OE_AB_HIGH);
  assign a_oe  = oe_on(ba_oe_ctl, OE_BA_HIGH);
endmodule

// File: tb/sim_reg_bus_xcvr.sv
module sim_reg_bus_xcvr;
  localparam int W = 18;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_STEPS = 4000;

  logic tb_clk = 1'b0;
  always #(CLK_PERIOD/2) tb_clk = ~tb_clk;

  logic         rst_n;
  logic [W-1:0] a_in, a_drv, a_out, b_in, b_drv, b_out;
  logic         a_oe, b_oe;
  logic         ab_oe_ctl, ab_le, ab_clk, ba_oe_ctl, ba_le, ba_clk;

  reg_bus_xcvr #(.WIDTH(W)) u0 (
    .rst_n(rst_n), .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe),
    .ab_oe_ctl(ab_oe_ctl), .ab_le(ab_le), .ab_clk(ab_clk),
    .ba_oe_ctl(ba_oe_ctl), .ba_le(ba_le), .ba_clk(ba_clk)
  );

  // External drivers and bench model state
  logic [W-1:0] ext_a_val, ext_a_mask, ext_b_val, ext_b_mask;
  logic [W-1:0] m_ab, m_ba, m_ka, m_kb;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [W-1:0] rnd_w();
    return W'({$urandom(), $urandom()});
  endfunction

  function automatic logic exp_b_oe(); return ab_oe_ctl; endfunction
  function automatic logic exp_a_oe(); return ~ba_oe_ctl; endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Resolve both buses for the model and the design, iterating so feed-through settles
  task automatic settle();
    logic [W-1:0] drv, val;
    for (int k = 0; k < 4; k++) begin
      drv  = exp_a_oe() ? '1 : ext_a_mask;
      val  = exp_a_oe() ? m_ba : ext_a_val;
      m_ka = (m_ka & ~drv) | (val & drv);
      drv  = exp_b_oe() ? '1 : ext_b_mask;
      val  = exp_b_oe() ? m_ab : ext_b_val;
      m_kb = (m_kb & ~drv) | (val & drv);
      if (ab_le) m_ab = m_ka;
      if (ba_le) m_ba = m_kb;
      a_drv = a_oe ? '1 : ext_a_mask;
      a_in  = a_oe ? a_out : ((ext_a_val & ext_a_mask) | (rnd_w() & ~ext_a_mask));
      b_drv = b_oe ? '1 : ext_b_mask;
      b_in  = b_oe ? b_out : ((ext_b_val & ext_b_mask) | (rnd_w() & ~ext_b_mask));
      #1;
    end
  endtask

  task automatic compare(input string req);
    chk(req, b_out, m_ab);
    chk(req, a_out, m_ba);
    chk({req, " oe"}, {{(W-2){1'b0}}, a_oe, b_oe}, {{(W-2){1'b0}}, exp_a_oe(), exp_b_oe()});
  endtask

  task automatic clk_ab(input logic lvl);
    @(negedge tb_clk);
    if (lvl && !ab_clk && !ab_le) m_ab = m_ka;
    ab_clk = lvl;
    settle();
  endtask

  task automatic clk_ba(input logic lvl);
    @(negedge tb_clk);
    if (lvl && !ba_clk && !ba_le) m_ba = m_kb;
    ba_clk = lvl;
    settle();
  endtask

  task automatic drive_a(input logic [W-1:0] v, input logic [W-1:0] m);
    @(negedge tb_clk);
    ext_a_val = v;
    ext_a_mask = exp_a_oe() ? '0 : m;
    settle();
  endtask

  task automatic drive_b(input logic [W-1:0] v, input logic [W-1:0] m);
    @(negedge tb_clk);
    ext_b_val = v;
    ext_b_mask = exp_b_oe() ? '0 : m;
    settle();
  endtask

  task automatic set_le(input bit ab_side, input logic lvl);
    @(negedge tb_clk);
    if (ab_side) ab_le = lvl; else ba_le = lvl;
    settle();
  endtask

  // Enable at most one direction so the buses never form a loop; external driver steps back
  task automatic set_oe(input logic ab_on, input logic ba_on);
    @(negedge tb_clk);
    ab_oe_ctl = ab_on && !ba_on;
    ba_oe_ctl = ~(ba_on && !ab_on);
    if (exp_b_oe()) ext_b_mask = '0;
    if (exp_a_oe()) ext_a_mask = '0;
    settle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v0, v1, held;
    void'($urandom(32'd1207));
    rst_n = 1'b0;
    ab_oe_ctl = 1'b0; ba_oe_ctl = 1'b1; ab_le = 1'b0; ba_le = 1'b0;
    ab_clk = 1'b0; ba_clk = 1'b0;
    ext_a_val = '0; ext_a_mask = '1; ext_b_val = '0; ext_b_mask = '1;
    m_ab = '0; m_ba = '0; m_ka = '0; m_kb = '0;
    settle();
    @(negedge tb_clk); rst_n = 1'b1; settle();
    repeat (2) begin
      clk_ab(1'b1); clk_ba(1'b1); clk_ab(1'b0); clk_ba(1'b0);
    end
    // R9: cleared after reset with latches closed
    chk("R9 b_out", b_out, '0);
    chk("R9 a_out", a_out, '0);

    // R1: open A-to-B latch, data passes without a clock
    v0 = 18'h2a5c3;
    set_le(1'b1, 1'b1);
    drive_a(v0, '1);
    chk("R1 b_out pass", b_out, v0);
    // R4: close latch, then change A: last transparent word kept
    set_le(1'b1, 1'b0);
    v1 = 18'h15a3c;
    drive_a(v1, '1);
    chk("R4 b_out kept", b_out, v0);
    // R2: more input changes with the clock held
    drive_a(~v0, '1);
    chk("R2 b_out hold", b_out, v0);
    // R3: rising edge loads, falling edge does nothing
    drive_a(v1, '1);
    clk_ab(1'b1);
    chk("R3 b_out edge", b_out, v1);
    drive_a(18'h3ffff, '1);
    clk_ab(1'b0);
    chk("R3 b_out fall", b_out, v1);
    // R10: A-to-B controls leave the B-to-A word and enable alone
    chk("R10 a_out", a_out, '0);
    chk("R10 a_oe", {{(W-1){1'b0}}, a_oe}, '0);
    // R5 / R6: enable polarities
    set_oe(1'b1, 1'b0);
    chk("R5 b_oe on", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, 1'b1});
    chk("R6 a_oe off", {{(W-1){1'b0}}, a_oe}, '0);
    set_oe(1'b0, 1'b1);
    chk("R6 a_oe on", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, 1'b1});
    chk("R5 b_oe off", {{(W-1){1'b0}}, b_oe}, '0);
    set_oe(1'b0, 1'b0);
    // R8: bus hold on the B port feeding an open B-to-A latch
    held = 18'h0f0f5;
    drive_b(held, '1);
    set_le(1'b0, 1'b1);
    chk("R8 a_out driven", a_out, held);
    drive_b(18'h3ffff, '0);
    chk("R8 a_out float", a_out, held);
    drive_b(18'h00000, 18'h000ff);
    chk("R8 a_out partial", a_out, {held[W-1:8], 8'h00});
    compare("R8 model");

    // R7: random single-control steps against the model
    for (int s = 0; s < RAND_STEPS; s++) begin
      case ($urandom % 8)
        0: drive_a(rnd_w(), ($urandom % 4 == 0) ? rnd_w() : '1);
        1: drive_b(rnd_w(), ($urandom % 4 == 0) ? rnd_w() : '1);
        2: set_le(1'b1, ~ab_le);
        3: set_le(1'b0, ~ba_le);
        4: clk_ab(~ab_clk);
        5: clk_ba(~ba_clk);
        6: set_oe(1'($urandom % 2), 1'($urandom % 2));
        default: drive_a(ext_a_val ^ (W'(1) << ($urandom % W)), '1);
      endcase
      compare("R7 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule